// File: doc/BRIEF.md
# Dual DAC Register Update Controller

This block keeps the two-stage register pair for each of two 16-bit converter channels, A and B. Each channel has an input (staging) register and a DAC (output) register. A serial front end, already running in the system clock domain, delivers decoded write events. Each event carries a target channel code, a data word, a strobe marking the ninth clock of a byte, and a flag that marks the final byte of a write. Only the final byte of a write commits data. It lands in the input register of the selected channel or channels and marks that channel as pending.

Two asynchronous pins control how staged data reaches the outputs. Each pin passes through a two-flop synchroniser.

- **Load pin:** while it is low, every pending channel copies its input register into its DAC register. A short low pulse therefore updates both outputs together. Holding the pin low makes writes flow straight through.
- **Clear pin:** its falling edge forces zero into every register and enters a clear mode. While the pin stays low, load requests have no effect. A clear that lands inside a write aborts that write. A clear also tells the front end to drop out of high-speed mode. Clear mode ends only when a later valid write commits.

Top module: `dual_dac_update`

## Requirements
- R1: After reset, dac_a and dac_b are 0, clear_mode is 0 and hs_drop is 0.
- R2: A strobe with last=1 and channel code 0 (A) or 1 (B) loads wr_data into that channel's input register. The DAC output does not change while ldac_n stays high.
- R3: While the synchronised ldac_n is low and the synchronised clr_n is high, every pending channel copies its input register into its DAC register. A single low pulse updates A and B in the same cycle.
- R4: Channel code 3 writes both channels. Channel code 2 writes neither, so a later load leaves both outputs unchanged.
- R5: With ldac_n held low, a committed write reaches its DAC output within a few cycles without any further pulse.
- R6: A falling edge on clr_n zeroes every input and DAC register and sets clear_mode to 1 on the following clock edge.
- R7: While clr_n is low, load requests are ignored. Data written in that time reaches the outputs only through a load after clr_n returns high.
- R8: clear_mode returns to 0 only on a committed write (strobe with last=1). A strobe with last=0 leaves it at 1.
- R9: If wr_active is 1 when the clear edge occurs, the rest of that write is discarded and clear_mode stays 1 until wr_active falls. The next write is accepted normally.
- R10: Each clear edge produces a one-cycle pulse on hs_drop on the next clock edge.
- R11: A strobe with last=0 changes neither register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_active | input | 1 | A write sequence is in progress on the serial bus |
| wr_strobe | input | 1 | One-cycle pulse at the ninth clock of a received byte |
| wr_last | input | 1 | The strobed byte is the final byte of the write |
| wr_chan | input | 2 | Target code: 0=A, 1=B, 2=none, 3=both |
| wr_data | input | 16 | Data word, valid with a final-byte strobe |
| ldac_n | input | 1 | Asynchronous load request, active low |
| clr_n | input | 1 | Asynchronous clear, falling-edge triggered |
| dac_a | output | 16 | Channel A DAC register |
| dac_b | output | 16 | Channel B DAC register |
| clear_mode | output | 1 | Clear mode is active |
| hs_drop | output | 1 | Pulse that asks the front end to leave high-speed mode |

## Verification
The bench drives the following corner cases, each with the failure it would expose:

- **Reserved channel code.** A design that treats code 2 as a channel would corrupt an output.
- **Strobe without the last flag.** A design that commits on it would load data early or leave clear mode too soon.
- **Load pulse while clear is held low.** A design that does not gate loads would show written data on an output that should stay at zero.
- **Clear arriving inside a write.** A design without an abort would accept that write's final byte and leave clear mode.
- **Load tied low.** A design that reacts only to pulses would never forward data.

// File: rtl/dacu_pkg.sv
package dacu_pkg;

  localparam int CHAN_W = 2;

  typedef enum logic [CHAN_W-1:0] {
    CH_A    = 2'd0,
    CH_B    = 2'd1,
    CH_NONE = 2'd2,
    CH_BOTH = 2'd3
  } chan_sel_e;

endpackage

// File: rtl/dacu_sync.sv
// Multi-flop synchroniser for an asynchronous pin with falling-edge pulse.
module dacu_sync #(
  parameter int   STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic fell
);

  logic [STAGES:0] sh_q;
  logic [STAGES:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-1:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= {(STAGES+1){RESET_VAL}};
    end else begin
      sh_q <= sh_d;
    end
  end

  assign level = sh_q[STAGES-1];
  assign fell  = sh_q[STAGES] & ~sh_q[STAGES-1];

endmodule

// File: rtl/dacu_ctrl.sv
// Clear mode, write abort, commit qualification and channel decode.
module dacu_ctrl
  import dacu_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_fell,
  input  logic              wr_active,
  input  logic              wr_strobe,
  input  logic              wr_last,
  input  logic [CHAN_W-1:0] wr_chan,
  output logic [NUM_CH-1:0] wr_sel,
  output logic              in_abort,
  output logic              clear_mode,
  output logic              hs_drop
);

  logic abort_q, abort_d;
  logic cmode_q, cmode_d;
  logic hs_q, hs_d;
  logic commit;

  assign commit = wr_strobe & wr_last & ~abort_q & ~clr_fell;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_CH; gi++) begin : g_dec
      assign wr_sel[gi] = commit &
                          ((wr_chan == CHAN_W'(gi)) || (wr_chan == CH_BOTH));
    end
  endgenerate

  always_comb begin
    abort_d = abort_q;
    if (clr_fell && wr_active) begin
      abort_d = 1'b1;
    end else if (!wr_active) begin
      abort_d = 1'b0;
    end

    cmode_d = cmode_q;
    if (clr_fell) begin
      cmode_d = 1'b1;
    end else if (commit) begin
      cmode_d = 1'b0;
    end

    hs_d = clr_fell;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abort_q <= 1'b0;
      cmode_q <= 1'b0;
      hs_q    <= 1'b0;
    end else begin
      abort_q <= abort_d;
      cmode_q <= cmode_d;
      hs_q    <= hs_d;
    end
  end

  assign in_abort   = abort_q;
  assign clear_mode = cmode_q;
  assign hs_drop    = hs_q;

endmodule

// File: rtl/dacu_chan.sv
// One channel: input register, pending flag and DAC register.
module dacu_chan #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              zero,
  input  logic              xfer_en,
  output logic [DATA_W-1:0] dac_q
);

  logic [DATA_W-1:0] inp_q, inp_d;
  logic [DATA_W-1:0] out_q, out_d;
  logic              pend_q, pend_d;
  logic              inp_en, out_en;

  always_comb begin
    inp_d  = inp_q;
    out_d  = out_q;
    pend_d = pend_q;
    if (zero) begin
      inp_d  = '0;
      out_d  = '0;
      pend_d = 1'b0;
    end else begin
      if (xfer_en && pend_q) begin
        out_d  = inp_q;
        pend_d = 1'b0;
      end
      if (wr_en) begin
        inp_d  = wr_data;
        pend_d = 1'b1;
      end
    end
  end

  assign inp_en = zero | wr_en;
  assign out_en = zero | (xfer_en & pend_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inp_q <= '0;
    end else if (inp_en) begin
      inp_q <= inp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (out_en) begin
      out_q <= out_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign dac_q = out_q;

endmodule

// File: rtl/dual_dac_update.sv
module dual_dac_update
  import dacu_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_active,
  input  logic              wr_strobe,
  input  logic              wr_last,
  input  logic [CHAN_W-1:0] wr_chan,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              ldac_n,
  input  logic              clr_n,
  output logic [DATA_W-1:0] dac_a,
  output logic [DATA_W-1:0] dac_b,
  output logic              clear_mode,
  output logic              hs_drop
);

  localparam int NUM_CH = 2;

  logic [1:0] rst_sh_q;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sh_q <= 2'b00;
    end else begin
      rst_sh_q <= {rst_sh_q[0], 1'b1};
    end
  end
  assign rst_s_n = rst_sh_q[1];

  logic ldac_lvl, ldac_fell;
  logic clr_lvl, clr_fell;
  logic [NUM_CH-1:0] wr_sel;
  logic in_abort;
  logic xfer_en;
  logic [DATA_W-1:0] dac_vec [NUM_CH];

  dacu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_ldac_sync (
    .clk(clk), .rst_n(rst_s_n), .din(ldac_n),
    .level(ldac_lvl), .fell(ldac_fell)
  );

  dacu_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_clr_sync (
    .clk(clk), .rst_n(rst_s_n), .din(clr_n),
    .level(clr_lvl), .fell(clr_fell)
  );

  dacu_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rst_n(rst_s_n), .clr_fell(clr_fell),
    .wr_active(wr_active), .wr_strobe(wr_strobe), .wr_last(wr_last),
    .wr_chan(wr_chan), .wr_sel(wr_sel), .in_abort(in_abort),
    .clear_mode(clear_mode), .hs_drop(hs_drop)
  );

  // Load is level based: a pulse or a tied-low pin both forward pending data.
  assign xfer_en = ~ldac_lvl & clr_lvl;

  genvar gc;
  generate
    for (gc = 0; gc < NUM_CH; gc++) begin : g_ch
      dacu_chan #(.DATA_W(DATA_W)) u_chan (
        .clk(clk), .rst_n(rst_s_n), .wr_en(wr_sel[gc]), .wr_data(wr_data),
        .zero(clr_fell), .xfer_en(xfer_en), .dac_q(dac_vec[gc])
      );
    end
  endgenerate

  assign dac_a = dac_vec[0];
  assign dac_b = dac_vec[1];

  logic unused_ok;
  assign unused_ok = ldac_fell;

endmodule

// File: rtl/dacu_chk.sv
module dacu_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic              clr_lvl,
  input logic              clr_fell,
  input logic              in_abort,
  input logic              wr_strobe,
  input logic              wr_last,
  input logic [DATA_W-1:0] dac_a,
  input logic [DATA_W-1:0] dac_b,
  input logic              clear_mode,
  input logic              hs_drop
);

  p_zero_on_clear_r6: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr_fell |=> (dac_a == '0 && dac_b == '0 && clear_mode));

  p_load_blocked_r7: assert property (@(posedge clk) disable iff (!rst_s_n)
    (!clr_lvl && !clr_fell) |=> ($stable(dac_a) && $stable(dac_b)));

  p_exit_on_write_r8: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(clear_mode) |-> $past(wr_strobe && wr_last));

  p_abort_discard_r9: assert property (@(posedge clk) disable iff (!rst_s_n)
    (in_abort && wr_strobe && !clr_fell) |=> $stable(clear_mode));

  p_hs_pulse_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    clr_fell |=> hs_drop);

  p_hs_single_r10: assert property (@(posedge clk) disable iff (!rst_s_n)
    hs_drop |=> !hs_drop);

endmodule

bind dual_dac_update dacu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_s_n(rst_s_n), .clr_lvl(clr_lvl), .clr_fell(clr_fell),
  .in_abort(in_abort), .wr_strobe(wr_strobe), .wr_last(wr_last),
  .dac_a(dac_a), .dac_b(dac_b), .clear_mode(clear_mode), .hs_drop(hs_drop)
);

// File: tb/test_dual_dac_update.sv
module test_dual_dac_update;

  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_active, wr_strobe, wr_last;
  logic [1:0]  wr_chan;
  logic [15:0] wr_data;
  logic        ldac_n, clr_n;
  logic [15:0] dac_a, dac_b;
  logic        clear_mode, hs_drop;

  int checks = 0;
  int errors = 0;
  int hs_cnt = 0;
  bit done   = 0;

  typedef struct {
    string       req;
    logic [15:0] a;
    logic [15:0] b;
    logic        cm;
  } exp_t;

  exp_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_dac_update i_dual_dac_update (
    .clk(clk), .rst_n(rst_n), .wr_active(wr_active), .wr_strobe(wr_strobe),
    .wr_last(wr_last), .wr_chan(wr_chan), .wr_data(wr_data),
    .ldac_n(ldac_n), .clr_n(clr_n), .dac_a(dac_a), .dac_b(dac_b),
    .clear_mode(clear_mode), .hs_drop(hs_drop)
  );

  // Monitor: pops expected items and compares them with the outputs.
  always @(negedge clk) begin
    if (hs_drop) hs_cnt++;
    while (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (dac_a !== e.a || dac_b !== e.b || clear_mode !== e.cm) begin
        errors++;
        $display("FAIL %s: got a=%h b=%h cm=%b, expected a=%h b=%h cm=%b",
                 e.req, dac_a, dac_b, clear_mode, e.a, e.b, e.cm);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_out(input string req, input logic [15:0] a,
                            input logic [15:0] b, input logic cm);
    exp_t e;
    e.req = req; e.a = a; e.b = b; e.cm = cm;
    sb_q.push_back(e);
    tick(1);
  endtask

  task automatic chk_int(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d, expected %0d", req, act, exp);
    end
  endtask

  task automatic strobe(input logic [1:0] ch, input logic [15:0] d,
                        input logic last);
    wr_chan = ch; wr_data = d; wr_last = last; wr_strobe = 1'b1;
    tick(1);
    wr_strobe = 1'b0; wr_last = 1'b0;
  endtask

  task automatic write(input logic [1:0] ch, input logic [15:0] d,
                       input logic last);
    wr_active = 1'b1;
    tick(1);
    strobe(ch, d, last);
    tick(1);
    wr_active = 1'b0;
    tick(2);
  endtask

  task automatic pulse_ldac();
    ldac_n = 1'b0;
    tick(4);
    ldac_n = 1'b1;
    tick(4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_active = 1'b0; wr_strobe = 1'b0; wr_last = 1'b0;
    wr_chan = 2'd0; wr_data = '0; ldac_n = 1'b1; clr_n = 1'b1;
    tick(3);
    rst_n = 1'b1;
    tick(4);
    expect_out("R1", 16'h0000, 16'h0000, 1'b0);
    chk_int("R1 hs_drop", int'(hs_drop), 0);

    write(2'd0, 16'h1234, 1'b1);
    expect_out("R2", 16'h0000, 16'h0000, 1'b0);

    write(2'd1, 16'hABCD, 1'b1);
    pulse_ldac();
    expect_out("R3", 16'h1234, 16'hABCD, 1'b0);

    write(2'd3, 16'h5555, 1'b1);
    pulse_ldac();
    expect_out("R4 both", 16'h5555, 16'h5555, 1'b0);
    write(2'd2, 16'h7777, 1'b1);
    pulse_ldac();
    expect_out("R4 none", 16'h5555, 16'h5555, 1'b0);

    write(2'd0, 16'h9999, 1'b0);
    pulse_ldac();
    expect_out("R11", 16'h5555, 16'h5555, 1'b0);

    ldac_n = 1'b0;
    tick(4);
    write(2'd0, 16'h0102, 1'b1);
    tick(2);
    expect_out("R5", 16'h0102, 16'h5555, 1'b0);
    ldac_n = 1'b1;
    tick(3);

    clr_n = 1'b0;
    tick(5);
    expect_out("R6", 16'h0000, 16'h0000, 1'b1);
    chk_int("R10 pulse count", hs_cnt, 1);

    write(2'd0, 16'h6666, 1'b0);
    expect_out("R8 non-last", 16'h0000, 16'h0000, 1'b1);

    write(2'd0, 16'h4321, 1'b1);
    expect_out("R8 exit", 16'h0000, 16'h0000, 1'b0);
    pulse_ldac();
    expect_out("R7 blocked", 16'h0000, 16'h0000, 1'b0);
    clr_n = 1'b1;
    tick(4);
    pulse_ldac();
    expect_out("R7 released", 16'h4321, 16'h0000, 1'b0);

    wr_active = 1'b1;
    tick(2);
    clr_n = 1'b0;
    tick(5);
    expect_out("R6 second", 16'h0000, 16'h0000, 1'b1);
    chk_int("R10 second pulse", hs_cnt, 2);
    clr_n = 1'b1;
    tick(3);
    strobe(2'd0, 16'h1111, 1'b1);
    tick(1);
    wr_active = 1'b0;
    tick(2);
    pulse_ldac();
    expect_out("R9 aborted", 16'h0000, 16'h0000, 1'b1);
    write(2'd1, 16'h2222, 1'b1);
    pulse_ldac();
    expect_out("R9 next write", 16'h0000, 16'h2222, 1'b0);

    tick(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule